// File: doc/BRIEF.md
# Difference-Summing Response Accumulator

This block compresses a stream of converter samples, taken while a built-in test runs, into one wide signature. Each enabled cycle adds one term to a sum split into a low and a high word. The term is chosen by a mode input: the stimulus word alone (to test the digital test logic without the converter), the raw converter sample, or the absolute difference between the stimulus word and the converter sample. The difference mode makes noise and phase shift in the analog path raise the final sum.

The caller must delay the stimulus word so that it lines up with the sample it produced. The caller drives `acc_en_i` for the length of the run. At the end, the caller compares the low word, the high word and the overflow flag against an acceptance window. An exact single value is not used, because component tolerance and converter noise move the sum. When the low word carries out, the high word goes up by one. When the high word carries out, a sticky overflow flag is set.

Top module: `sig_accum`

## Requirements
- R1: While `rst` is high at a clock edge, `sum_lo_o`, `sum_hi_o` and `ovf_o` become zero.
- R2: When `clr_i` is high at an edge, both sum words and `ovf_o` become zero at that edge, even if `acc_en_i` is also high.
- R3: When `acc_en_i` is low and `clr_i` is low, the sum words and `ovf_o` keep their values, whatever the mode, stimulus and sample inputs carry.
- R4: With `mode_i` = 2'b01 (magnitude), each enabled edge adds `adc_i`, zero-extended, to the sum.
- R5: With `mode_i` = 2'b10 (difference), each enabled edge adds |`stim_i` − `adc_i`|, taken on unsigned values. The result is correct whichever operand is larger and never wraps; for example, 0 against 255 adds 255.
- R6: With `mode_i` = 2'b00 (self-test), each enabled edge adds `stim_i`, zero-extended, and ignores `adc_i`.
- R7: With `mode_i` = 2'b11, an enabled edge adds nothing, so the outputs keep their values.
- R8: The two words together form one number of 2·ACC_W bits, `{sum_hi_o, sum_lo_o}`. A carry out of the low word raises the high word by exactly one at the same edge.
- R9: A carry out of the high word sets `ovf_o`, and the sum wraps modulo 2^(2·ACC_W). `ovf_o` then stays high until the next clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of the sum and the flag |
| acc_en_i | input | 1 | Adds one term at this edge |
| mode_i | input | 2 | 00 self-test, 01 magnitude, 10 difference, 11 no add |
| stim_i | input | DAC_W | Stimulus word, already aligned with the sample |
| adc_i | input | ADC_W | Converter sample |
| sum_lo_o | output | ACC_W | Low word of the signature |
| sum_hi_o | output | ACC_W | High word of the signature |
| ovf_o | output | 1 | Sticky carry out of the high word |

## Verification
Two pairs of events can fall on the same edge. First, a clear can arrive on the same edge as an enabled add. The bench raises `clr_i` and `acc_en_i` together while a large term is present, then expects an all-zero result. Second, a low-word carry can arrive on the same edge as a high-word carry. The bench pushes the sum to 2^16−1 and adds once more. It expects the wrapped low and high words and the overflow flag, all at that single edge, and it checks them against a bench-side integer model.

// File: rtl/sig_accum_pkg.sv
package sig_accum_pkg;

    typedef enum logic [1:0] {
        MODE_SELF = 2'b00,
        MODE_MAG  = 2'b01,
        MODE_DIFF = 2'b10,
        MODE_IDLE = 2'b11
    } acc_mode_e;

    typedef struct packed {
        logic lo_carry;
        logic hi_carry;
    } carry_t;

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sig_accum_absdiff.sv
module sig_accum_absdiff #(
    parameter int DAC_W = 8,
    parameter int ADC_W = 8,
    parameter int CMP_W = 8
) (
    input  logic [DAC_W-1:0] stim_i,
    input  logic [ADC_W-1:0] adc_i,
    output logic [CMP_W-1:0] diff_o
);
    logic [CMP_W-1:0] a_w;
    logic [CMP_W-1:0] b_w;

    always_comb begin
        a_w = CMP_W'(stim_i);
        b_w = CMP_W'(adc_i);
        // Subtract the smaller value from the larger, so the result cannot wrap
        if (a_w >= b_w) diff_o = a_w - b_w;
        else            diff_o = b_w - a_w;
    end
endmodule

// File: rtl/sig_accum_select.sv
module sig_accum_select
    import sig_accum_pkg::*;
#(
    parameter int DAC_W = 8,
    parameter int ADC_W = 8,
    parameter int CMP_W = 8
) (
    input  acc_mode_e        mode_i,
    input  logic [DAC_W-1:0] stim_i,
    input  logic [ADC_W-1:0] adc_i,
    input  logic [CMP_W-1:0] diff_i,
    output logic [CMP_W-1:0] term_o
);
    always_comb begin
        unique case (mode_i)
            MODE_SELF: term_o = CMP_W'(stim_i);
            MODE_MAG:  term_o = CMP_W'(adc_i);
            MODE_DIFF: term_o = diff_i;
            default:   term_o = '0;
        endcase
    end
endmodule

// File: rtl/sig_accum_core.sv
module sig_accum_core
    import sig_accum_pkg::*;
#(
    parameter int CMP_W = 8,
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CMP_W-1:0] term_i,
    output logic [ACC_W-1:0] lo_o,
    output logic [ACC_W-1:0] hi_o,
    output logic             ovf_o
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] lo_q, hi_q;
    logic             ovf_q;
    logic [SUM_W-1:0] lo_sum, hi_sum;
    carry_t           cy;

    always_comb begin
        lo_sum      = {1'b0, lo_q} + SUM_W'(term_i);
        cy.lo_carry = lo_sum[ACC_W];
        hi_sum      = {1'b0, hi_q} + SUM_W'(cy.lo_carry);
        cy.hi_carry = hi_sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            lo_q  <= '0;
            hi_q  <= '0;
            ovf_q <= 1'b0;
        end else if (en_i) begin
            lo_q <= lo_sum[ACC_W-1:0];
            hi_q <= hi_sum[ACC_W-1:0];
            if (cy.hi_carry) ovf_q <= 1'b1;
        end
    end

    assign lo_o  = lo_q;
    assign hi_o  = hi_q;
    assign ovf_o = ovf_q;
endmodule

// File: rtl/sig_accum.sv
module sig_accum
    import sig_accum_pkg::*;
#(
    parameter int DAC_W = 8,
    parameter int ADC_W = 8,
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             acc_en_i,
    input  logic [1:0]       mode_i,
    input  logic [DAC_W-1:0] stim_i,
    input  logic [ADC_W-1:0] adc_i,
    output logic [ACC_W-1:0] sum_lo_o,
    output logic [ACC_W-1:0] sum_hi_o,
    output logic             ovf_o
);
    localparam int CMP_W = max_w(DAC_W, ADC_W);

    acc_mode_e        mode;
    logic [CMP_W-1:0] diff;
    logic [CMP_W-1:0] term;

    assign mode = acc_mode_e'(mode_i);

    sig_accum_absdiff #(.DAC_W(DAC_W), .ADC_W(ADC_W), .CMP_W(CMP_W)) absdiff_i (
        .stim_i (stim_i),
        .adc_i  (adc_i),
        .diff_o (diff)
    );

    sig_accum_select #(.DAC_W(DAC_W), .ADC_W(ADC_W), .CMP_W(CMP_W)) select_i (
        .mode_i (mode),
        .stim_i (stim_i),
        .adc_i  (adc_i),
        .diff_i (diff),
        .term_o (term)
    );

    sig_accum_core #(.CMP_W(CMP_W), .ACC_W(ACC_W)) core_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .en_i   (acc_en_i),
        .term_i (term),
        .lo_o   (sum_lo_o),
        .hi_o   (sum_hi_o),
        .ovf_o  (ovf_o)
    );
endmodule

// File: rtl/sig_accum_chk.sv
module sig_accum_chk #(
    parameter int ACC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             acc_en_i,
    input logic [1:0]       mode_i,
    input logic [ACC_W-1:0] sum_lo_o,
    input logic [ACC_W-1:0] sum_hi_o,
    input logic             ovf_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (sum_lo_o == '0 && sum_hi_o == '0 && !ovf_o));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (sum_lo_o == '0 && sum_hi_o == '0 && !ovf_o));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !acc_en_i) |=> ($stable(sum_lo_o) && $stable(sum_hi_o) && $stable(ovf_o)));

    // R7
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && acc_en_i && mode_i == 2'b11) |=> ($stable(sum_lo_o) && $stable(sum_hi_o)));

    // R8
    hi_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (sum_hi_o == $past(sum_hi_o) || sum_hi_o == ACC_W'($past(sum_hi_o) + 1'b1)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o);

    // R9
    ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(&sum_hi_o));
endmodule

bind sig_accum sig_accum_chk #(.ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .acc_en_i (acc_en_i),
    .mode_i   (mode_i),
    .sum_lo_o (sum_lo_o),
    .sum_hi_o (sum_hi_o),
    .ovf_o    (ovf_o)
);

// File: tb/sig_accum_tb_top.sv
`timescale 1ns/1ps
module sig_accum_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         clr_i;
    logic         acc_en_i;
    logic [1:0]   mode_i;
    logic [W-1:0] stim_i;
    logic [W-1:0] adc_i;
    logic [W-1:0] sum_lo_o;
    logic [W-1:0] sum_hi_o;
    logic         ovf_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model of the sum
    longint total = 0;
    bit     m_ovf = 0;

    always #2 clk = ~clk;

    sig_accum #(.DAC_W(W), .ADC_W(W), .ACC_W(W)) dut_i (
        .clk(clk), .rst(rst), .clr_i(clr_i), .acc_en_i(acc_en_i),
        .mode_i(mode_i), .stim_i(stim_i), .adc_i(adc_i),
        .sum_lo_o(sum_lo_o), .sum_hi_o(sum_hi_o), .ovf_o(ovf_o)
    );

    function automatic longint term_of(input logic [1:0] m, input int s, input int a);
        case (m)
            2'b00:   return s;
            2'b01:   return a;
            2'b10:   return (s >= a) ? s - a : a - s;
            default: return 0;
        endcase
    endfunction

    // one edge: drive at negedge, update model, sample at next negedge
    task automatic cyc(input logic [1:0] m, input int s, input int a, input bit en, input bit clr);
        mode_i = m; stim_i = W'(s); adc_i = W'(a); acc_en_i = en; clr_i = clr;
        @(negedge clk);
        if (clr) begin
            total = 0; m_ovf = 0;
        end else if (en) begin
            total = total + term_of(m, s, a);
            if (total >= 65536) begin
                total = total - 65536;
                m_ovf = 1;
            end
        end
    endtask

    task automatic check(input string req);
        longint act;
        act = {sum_hi_o, sum_lo_o};
        checks++;
        if (act != total || ovf_o != m_ovf) begin
            failures++;
            $display("FAIL %s: sum=%0d ovf=%0d expected sum=%0d ovf=%0d", req, act, ovf_o, total, m_ovf);
        end
    endtask

    task automatic t_reset();
        rst = 1; clr_i = 0; acc_en_i = 0; mode_i = 0; stim_i = 0; adc_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        total = 0; m_ovf = 0;
        check("R1");
    endtask

    task automatic t_magnitude();
        for (int i = 0; i < 3; i++) cyc(2'b01, 99, 37, 1, 0);
        check("R4");
    endtask

    task automatic t_difference();
        cyc(2'b10, 200, 50, 1, 0);
        check("R5 stim larger");
        cyc(2'b10, 10, 240, 1, 0);
        check("R5 sample larger");
        cyc(2'b10, 0, 255, 1, 0);
        check("R5 no wrap");
        cyc(2'b10, 77, 77, 1, 0);
        check("R5 equal");
    endtask

    task automatic t_selftest();
        cyc(2'b00, 45, 255, 1, 0);
        cyc(2'b00, 3, 0, 1, 0);
        check("R6");
    endtask

    task automatic t_idle_mode();
        cyc(2'b11, 250, 250, 1, 0);
        cyc(2'b11, 9, 1, 1, 0);
        check("R7");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4; i++) cyc(2'(i), 200 - i, 30 + i, 0, 0);
        check("R3");
    endtask

    task automatic t_clear_vs_enable();
        cyc(2'b01, 0, 250, 1, 1);
        check("R2 clear beats enable");
    endtask

    task automatic t_carry();
        cyc(2'b01, 0, 200, 1, 0);
        check("R8 before carry");
        cyc(2'b01, 0, 200, 1, 0);
        check("R8 low carry into high");
    endtask

    task automatic t_overflow();
        cyc(2'b01, 0, 0, 0, 1);
        for (int i = 0; i < 257; i++) cyc(2'b01, 0, 255, 1, 0);
        check("R9 full without overflow");
        cyc(2'b01, 0, 255, 1, 0);
        check("R9 high carry sets flag");
        cyc(2'b01, 0, 10, 1, 0);
        cyc(2'b00, 0, 0, 0, 0);
        check("R9 flag sticky");
        cyc(2'b01, 0, 0, 0, 1);
        check("R9 cleared");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_magnitude();
        t_difference();
        t_selftest();
        t_idle_mode();
        t_hold();
        t_clear_vs_enable();
        t_carry();
        t_overflow();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule